// File: doc/BRIEF.md
# Cascadable Priority Encoder

This block reduces a bank of request lines to the binary index of the most urgent one. All of its pins are active low: a request line pulled to 0 is a request, and the index comes out inverted. The block is built from identical 8-request slices. Each slice has an enable input, a group-select output and an enable output. A slice's enable output drives the enable input of the slice one step lower in priority. A slice that sees an active request therefore silences every slice below it.

The top module chains `SLICES` slices (two by default, giving 16 requests). A second, narrow slice encodes which slice owns the winning request, and that result forms the upper code bits. The lower code bits are the bitwise AND of the slices' active-low codes, which works because an idle or disabled slice drives all ones. The whole path is combinational: there are no registers, latches or handshakes. The top-level enable and enable output let the complete encoder itself be chained into a wider one.

Top module: `prienc_chain`

## Requirements
- R1: While `ein_n` is 1 (disabled), `code_n` is all ones and `gs_n` and `eo_n` are both 1, whatever the requests are.
- R2: While enabled (`ein_n` = 0) with every `req_n` bit at 1, `code_n` is all ones, `gs_n` is 1 and `eo_n` is 0.
- R3: While enabled with at least one `req_n` bit at 0, `gs_n` is 0 and `eo_n` is 1.
- R4: While enabled with a request active, `code_n` equals the bitwise inverse of the index of the highest-numbered `req_n` bit that is 0 (bit 15 is the most urgent). The index is 4 bits, bit 3 the MSB.
- R5: With only request 6 active, `code_n` reads 4'b1001, that is, low bits 001.
- R6: Requests below the winning one have no effect on `code_n`, including when they sit in a lower slice that the chain has disabled.
- R7: While enabled, `code_n[3]` is 0 exactly when some request among bits 15..8 is active.
- R8: `gs_n` and `eo_n` are never 0 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ein_n | input | 1 | Enable in, active low; 1 forces every output inactive |
| req_n | input | 16 | Request lines, active low, bit 15 most urgent |
| code_n | output | 4 | Inverted index of the winning request |
| gs_n | output | 1 | Low when enabled and any request is active |
| eo_n | output | 1 | Low when enabled and no request is active; feeds the next lower encoder |

## Verification
The checks assume that `ein_n` and `req_n` are settled two-level values when they are evaluated. They also assume the default two-slice geometry, so that bit 3 of `code_n` names the upper slice. The bench changes the inputs only away from the sampling point and lets the combinational path settle before it looks at any output. It visits every one of the 65536 request patterns with the block enabled, plus directed patterns with the block disabled. Every pattern stays within these assumptions.

// File: rtl/prienc_pkg.sv
`timescale 1ns/1ps
package prienc_pkg;
   localparam int DEF_SLICE_W = 8;
   localparam int DEF_SLICES  = 2;

   function automatic bit is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/prienc_slice.sv
`timescale 1ns/1ps
module prienc_slice #(
   parameter int W = 8,
   localparam int CW = $clog2(W)
) (
   input  logic          ein_n,
   input  logic [W-1:0]  req_n,
   output logic [CW-1:0] code_n,
   output logic          gs_n,
   output logic          eo_n
);
   import prienc_pkg::*;

   generate
      if (!is_pow2(W)) begin : g_bad_w
         $error("prienc_slice: W must be a power of two, at least 2");
      end
   endgenerate

   logic          hit;
   logic [CW-1:0] idx;

   // Ascending scan: the last active line seen is the most urgent one.
   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = 0; i < W; i++) begin
         if (!req_n[i]) begin
            hit = 1'b1;
            idx = CW'(i);
         end
      end
   end

   assign code_n = (ein_n || !hit) ? '1 : ~idx;
   assign gs_n   = ein_n | ~hit;
   assign eo_n   = ein_n | hit;
endmodule

// File: rtl/prienc_merge.sv
`timescale 1ns/1ps
module prienc_merge #(
   parameter int SLICES = 2,
   parameter int CW     = 3
) (
   input  logic [SLICES-1:0][CW-1:0] codes_n,
   output logic [CW-1:0]             code_n
);
   // Idle slices drive all ones, so the AND keeps only the winner's code.
   always_comb begin
      code_n = '1;
      for (int s = 0; s < SLICES; s++) code_n &= codes_n[s];
   end
endmodule

// File: rtl/prienc_chain.sv
`timescale 1ns/1ps
module prienc_chain #(
   parameter int SLICE_W = prienc_pkg::DEF_SLICE_W,
   parameter int SLICES  = prienc_pkg::DEF_SLICES,
   localparam int LCW  = $clog2(SLICE_W),
   localparam int HCW  = $clog2(SLICES),
   localparam int CW   = LCW + HCW,
   localparam int REQS = SLICE_W * SLICES
) (
   input  logic            ein_n,
   input  logic [REQS-1:0] req_n,
   output logic [CW-1:0]   code_n,
   output logic            gs_n,
   output logic            eo_n
);
   import prienc_pkg::*;

   generate
      if (!is_pow2(SLICES)) begin : g_bad_slices
         $error("prienc_chain: SLICES must be a power of two, at least 2");
      end
   endgenerate

   logic [SLICES:0]              chain_n;
   logic [SLICES-1:0]            sgs_n;
   logic [SLICES-1:0][LCW-1:0]   scode_n;
   logic [LCW-1:0]               lo_n;
   logic [HCW-1:0]               hi_n;
   logic                         grp_eo_n;

   // The most urgent slice takes the external enable; each one enables the next lower.
   assign chain_n[SLICES] = ein_n;

   generate
      for (genvar s = 0; s < SLICES; s++) begin : g_slice
         prienc_slice #(.W(SLICE_W)) u_slice (
            .ein_n  (chain_n[s+1]),
            .req_n  (req_n[s*SLICE_W +: SLICE_W]),
            .code_n (scode_n[s]),
            .gs_n   (sgs_n[s]),
            .eo_n   (chain_n[s])
         );
      end
   endgenerate

   // A narrow encoder over the group selects names the owning slice.
   prienc_slice #(.W(SLICES)) u_group (
      .ein_n  (ein_n),
      .req_n  (sgs_n),
      .code_n (hi_n),
      .gs_n   (gs_n),
      .eo_n   (grp_eo_n)
   );

   prienc_merge #(.SLICES(SLICES), .CW(LCW)) u_merge (
      .codes_n (scode_n),
      .code_n  (lo_n)
   );

   assign code_n = {hi_n, lo_n};
   // The chain tail and the group encoder agree; both are low only when enabled and idle.
   assign eo_n   = chain_n[0] & grp_eo_n;
endmodule

// File: rtl/prienc_chain_chk.sv
`timescale 1ns/1ps
module prienc_chain_chk #(
   parameter int SLICE_W = 8,
   parameter int SLICES  = 2,
   localparam int CW   = $clog2(SLICE_W) + $clog2(SLICES),
   localparam int REQS = SLICE_W * SLICES,
   localparam int HALF = REQS / 2
) (
   input logic            ein_n,
   input logic [REQS-1:0] req_n,
   input logic [CW-1:0]   code_n,
   input logic            gs_n,
   input logic            eo_n
);
   always_comb begin
      if (ein_n) begin
         // R1
         disabled_quiet_chk: assert ((&code_n) && gs_n && eo_n);
      end
      if (!ein_n && (&req_n)) begin
         // R2
         idle_pass_chk: assert ((&code_n) && gs_n && !eo_n);
      end
      if (!ein_n && !(&req_n)) begin
         // R3
         active_group_chk: assert (!gs_n && eo_n);
      end
      if (!ein_n) begin
         // R7
         upper_half_chk: assert (code_n[CW-1] == (&req_n[REQS-1 -: HALF]));
      end
      // R8
      gs_eo_exclusive_chk: assert (gs_n || eo_n);
   end
endmodule

bind prienc_chain prienc_chain_chk #(.SLICE_W(SLICE_W), .SLICES(SLICES)) u_chk (
   .ein_n  (ein_n),
   .req_n  (req_n),
   .code_n (code_n),
   .gs_n   (gs_n),
   .eo_n   (eo_n)
);

// File: tb/prienc_chain_bench.sv
`timescale 1ns/1ps
module prienc_chain_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ein_n = 1'b1;
   logic [15:0] req_n = '1;
   logic [3:0]  code_n;
   logic        gs_n, eo_n;
   int          errors = 0;
   int          checks = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   prienc_chain u_prienc_chain (
      .ein_n(ein_n), .req_n(req_n), .code_n(code_n), .gs_n(gs_n), .eo_n(eo_n)
   );

   // Vector layout: {ein_n, req_n[15:0], code_n[3:0], gs_n, eo_n}
   localparam logic [22:0] VEC [10] = '{
      {1'b1, 16'h0000, 4'hF, 1'b1, 1'b1},  // R1 disabled, all requests active
      {1'b0, 16'hFFFF, 4'hF, 1'b1, 1'b0},  // R2 enabled, idle
      {1'b0, 16'hFFBF, 4'h9, 1'b0, 1'b1},  // R5 only request 6
      {1'b0, 16'h7FFF, 4'h0, 1'b0, 1'b1},  // R4 only request 15
      {1'b0, 16'hFFFE, 4'hF, 1'b0, 1'b1},  // R4 only request 0
      {1'b0, 16'h0000, 4'h0, 1'b0, 1'b1},  // R6 every request active
      {1'b0, 16'hFE7F, 4'h7, 1'b0, 1'b1},  // R7 requests 8 and 7
      {1'b0, 16'hFF7E, 4'h8, 1'b0, 1'b1},  // R7 requests 7 and 0
      {1'b1, 16'hFFBF, 4'hF, 1'b1, 1'b1},  // R1 disabled, request 6
      {1'b0, 16'hFDF7, 4'h6, 1'b0, 1'b1}   // R6 requests 9 and 3
   };

   task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: {code_n,gs_n,eo_n} actual=%b expected=%b (ein_n=%b req_n=%h)",
                  tag, act, exp, ein_n, req_n);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1 reset state", {code_n, gs_n, eo_n}, 6'b1111_11);

      for (int v = 0; v < 10; v++) begin
         @(negedge clk);
         {ein_n, req_n} = VEC[v][22:6];
         #1;
         chk($sformatf("R1/R2/R4/R5/R6/R7 table vec %0d", v), {code_n, gs_n, eo_n}, VEC[v][5:0]);
      end

      // Exhaustive sweep, enabled, against a reference scan
      ein_n = 1'b0;
      for (int p = 0; p < 65536; p++) begin
         logic [3:0] ref_idx;
         logic       ref_hit;
         @(negedge clk);
         req_n = p[15:0];
         ref_hit = 1'b0;
         ref_idx = 4'h0;
         for (int i = 15; i >= 0; i--) begin
            if (!ref_hit && !req_n[i]) begin
               ref_hit = 1'b1;
               ref_idx = 4'(i);
            end
         end
         #1;
         if (ref_hit) chk("R3/R4 sweep", {code_n, gs_n, eo_n}, {~ref_idx, 2'b01});
         else         chk("R2 sweep", {code_n, gs_n, eo_n}, 6'b1111_10);
         if (!gs_n && !eo_n) chk("R8 sweep", {code_n, gs_n, eo_n}, {code_n, 2'b11});
      end

      // R6: a lower request changes nothing while request 12 wins
      @(negedge clk);
      req_n = 16'hEFFF; #1;
      chk("R6 upper alone", {code_n, gs_n, eo_n}, {4'b0011, 2'b01});
      @(negedge clk);
      req_n = 16'hEF00; #1;
      chk("R6 lower slice masked", {code_n, gs_n, eo_n}, {4'b0011, 2'b01});
      @(negedge clk);
      ein_n = 1'b1; #1;
      chk("R1 disable after activity", {code_n, gs_n, eo_n}, 6'b1111_11);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule